// File: doc/BRIEF.md
# Byte-Window Instruction RAM Loader

This block gives a host a narrow path into a sequencer's instruction store. The store holds 32-bit words, but the host reaches it through a single byte-wide data window. A host writes four bytes in a row to that window, lowest byte first. The block collects them and commits the whole word on the fourth byte. The word address then steps forward by itself, so a program image streams in with no address writes between words.

The word address is 9 bits wide. It is set through two address registers: one holds bits 7..0, and bit 0 of the other holds bit 8. A control register holds two bits. One is a load permission, without which data writes are dropped. The other is a rewind bit, which pins the address and the byte position at zero. Reads through the data window walk the store the same way writes do, so a loaded image can be checked byte for byte.

Top module: `instr_ram_loader`

## Requirements
- R1: After reset the control bits, the word address and the byte position are all zero, so reads of control (select 0), address low (select 2) and address high (select 3) return 0x00.
- R2: With load set and rewind clear, four writes to the data window (select 1) build one word, lowest byte first. The word is written to the store only on the fourth byte.
- R3: Committing a word raises the word address by one, and the address wraps from 511 to 0.
- R4: A write to address low (select 2) sets address bits 7..0. A write to address high (select 3) sets address bit 8 from data bit 0 and ignores the other data bits. A read of address high returns bit 8 in bit 0 and zero above it.
- R5: With load (control bit 0) clear, data-window writes are ignored: the store, the address and the byte position are all left unchanged.
- R6: While rewind (control bit 1) is set, the address and the byte position are held at zero, even if address writes arrive. Data-window writes do not reach the store in this state.
- R7: A write to either address register returns the byte position to zero.
- R8: A read of the data window returns the byte at the current byte position of the word at the current address, then advances that position. After the fourth byte the address rises by one. This happens whatever the load bit is.
- R9: A read of control returns load in bit 0, rewind in bit 1 and zeros in bits 7..2. Control data bits 7..2 are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Register write strobe, one per cycle held high |
| host_rd | input | 1 | Register read strobe, side effects only on the data window |
| host_sel | input | 2 | Register select: 0 control, 1 data window, 2 address low, 3 address high |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Read data for the selected register, combinational |

## Verification
On every cycle, the assertions check several things:
- the store is written only on a fourth byte, and only while load is set;
- each commit, and each fourth read, steps the address by exactly one;
- an ignored data write leaves the position and the address unchanged;
- address writes and rewind return the position to zero;
- reads step the position by one.

Only the bench scenarios can show the actual content of the store. That covers the lowest-first byte order, the word that survives a blocked or rewound load, and the wrap from 511 to 0 seen through a read-back. It also covers the masking of unused control and address-high bits.

// File: rtl/ildr_pkg.sv
package ildr_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_DATA    = 2'd1,
        SEL_ADDR_LO = 2'd2,
        SEL_ADDR_HI = 2'd3
    } reg_sel_e;

    localparam int CTRL_LOAD_BIT = 0;
    localparam int CTRL_RWND_BIT = 1;
    localparam int BYTE_W        = 8;

endpackage

// File: rtl/ildr_regs.sv
module ildr_regs
    import ildr_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int BYTES  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  reg_sel_e                      sel,
    input  logic [BYTE_W-1:0]             wdata,
    output logic [ADDR_W-1:0]             addr,
    output logic [$clog2(BYTES)-1:0]      byte_idx,
    output logic                          load_en,
    output logic                          rwnd,
    output logic                          mem_we,
    output logic [BYTES*BYTE_W-1:0]       mem_wdata
);
    localparam int IDX_W   = $clog2(BYTES);
    localparam int STAGE_W = (BYTES - 1) * BYTE_W;
    localparam int HI_W    = ADDR_W - BYTE_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES - 1);

    typedef struct packed {
        logic               load;
        logic               rwnd;
        logic [ADDR_W-1:0]  addr;
        logic [IDX_W-1:0]   idx;
        logic [STAGE_W-1:0] stage;
    } ldr_state_t;

    ldr_state_t st_d, st_q;
    logic       we_d;

    always_comb begin
        st_d = st_q;
        we_d = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_CTRL: begin
                    st_d.load = wdata[CTRL_LOAD_BIT];
                    st_d.rwnd = wdata[CTRL_RWND_BIT];
                end
                SEL_ADDR_LO: begin
                    st_d.addr[BYTE_W-1:0] = wdata;
                    st_d.idx              = '0;
                end
                SEL_ADDR_HI: begin
                    st_d.addr[ADDR_W-1:BYTE_W] = wdata[HI_W-1:0];
                    st_d.idx                   = '0;
                end
                SEL_DATA: begin
                    if (st_q.load && !st_q.rwnd) begin
                        if (st_q.idx == LAST_IDX) begin
                            we_d      = 1'b1;
                            st_d.idx  = '0;
                            st_d.addr = st_q.addr + 1'b1;
                        end else begin
                            for (int b = 0; b < BYTES - 1; b++) begin
                                if (st_q.idx == IDX_W'(b)) begin
                                    st_d.stage[b*BYTE_W +: BYTE_W] = wdata;
                                end
                            end
                            st_d.idx = st_q.idx + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end else if (rd_en && sel == SEL_DATA && !st_q.rwnd) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.idx  = '0;
                st_d.addr = st_q.addr + 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
        if (st_d.rwnd) begin
            st_d.addr = '0;
            st_d.idx  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr      = st_q.addr;
    assign byte_idx  = st_q.idx;
    assign load_en   = st_q.load;
    assign rwnd      = st_q.rwnd;
    assign mem_we    = we_d;
    assign mem_wdata = {wdata, st_q.stage};

endmodule

// File: rtl/ildr_mem.sv
module ildr_mem #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[addr] <= wdata;
        end
    end

    assign rdata = store_q[addr];

endmodule

// File: rtl/ildr_rdmux.sv
module ildr_rdmux
    import ildr_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int BYTES  = 4
) (
    input  reg_sel_e                     sel,
    input  logic [BYTES*BYTE_W-1:0]      word,
    input  logic [$clog2(BYTES)-1:0]     byte_idx,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         load_en,
    input  logic                         rwnd,
    output logic [BYTE_W-1:0]            rdata
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic [BYTE_W-1:0] lane [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lane[g] = word[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CTRL: begin
                rdata[CTRL_LOAD_BIT] = load_en;
                rdata[CTRL_RWND_BIT] = rwnd;
            end
            SEL_DATA:    rdata = lane[byte_idx];
            SEL_ADDR_LO: rdata = addr[BYTE_W-1:0];
            SEL_ADDR_HI: rdata[HI_W-1:0] = addr[ADDR_W-1:BYTE_W];
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/instr_ram_loader.sv
module instr_ram_loader
    import ildr_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int BYTES  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [1:0] host_sel,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata
);
    localparam int WORD_W = BYTES * BYTE_W;
    localparam int IDX_W  = $clog2(BYTES);

    reg_sel_e          sel;
    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  cur_idx;
    logic              load_en;
    logic              rwnd;
    logic              mem_we;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rdata;

    assign sel = reg_sel_e'(host_sel);

    ildr_regs #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr),
        .rd_en     (host_rd),
        .sel       (sel),
        .wdata     (host_wdata),
        .addr      (cur_addr),
        .byte_idx  (cur_idx),
        .load_en   (load_en),
        .rwnd      (rwnd),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata)
    );

    ildr_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (cur_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    ildr_rdmux #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_rdmux (
        .sel      (sel),
        .word     (mem_rdata),
        .byte_idx (cur_idx),
        .addr     (cur_addr),
        .load_en  (load_en),
        .rwnd     (rwnd),
        .rdata    (host_rdata)
    );

endmodule

// File: rtl/instr_ram_loader_chk.sv
module instr_ram_loader_chk
    import ildr_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int BYTES  = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     host_wr,
    input logic                     host_rd,
    input logic [1:0]               host_sel,
    input logic                     wr_rwnd_bit,
    input logic [ADDR_W-1:0]        addr,
    input logic [$clog2(BYTES)-1:0] idx,
    input logic                     mem_we,
    input logic                     load_en,
    input logic                     rwnd
);
    localparam int IDX_W = $clog2(BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES - 1);

    logic [ADDR_W-1:0] addr_nxt;
    logic [IDX_W-1:0]  idx_nxt;
    logic              data_wr, data_rd, addr_wr;

    assign addr_nxt = addr + 1'b1;
    assign idx_nxt  = idx + 1'b1;
    assign data_wr  = host_wr && host_sel == SEL_DATA;
    assign data_rd  = host_rd && !host_wr && host_sel == SEL_DATA && !rwnd;
    assign addr_wr  = host_wr && (host_sel == SEL_ADDR_LO || host_sel == SEL_ADDR_HI);

    AST_WE_ON_LAST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> data_wr && idx == LAST_IDX);  // R2

    AST_COMMIT_STEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> addr == $past(addr_nxt));  // R3

    AST_NO_LOAD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |-> !mem_we);  // R5

    AST_IGNORED_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && !load_en |=> $stable(idx) && $stable(addr));  // R5

    AST_RWND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_sel == SEL_CTRL && wr_rwnd_bit |=> addr == '0 && idx == '0);  // R6

    AST_ADDR_WR_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> idx == '0);  // R7

    AST_RD_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && idx != LAST_IDX |=> idx == $past(idx_nxt) && $stable(addr));  // R8

    AST_RD_LAST_STEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && idx == LAST_IDX |=> idx == '0 && addr == $past(addr_nxt));  // R8

endmodule

bind instr_ram_loader instr_ram_loader_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_sel    (host_sel),
    .wr_rwnd_bit (host_wdata[1]),
    .addr        (cur_addr),
    .idx         (cur_idx),
    .mem_we      (mem_we),
    .load_en     (load_en),
    .rwnd        (rwnd)
);

// File: tb/instr_ram_loader_bench.sv
`timescale 1ns/1ps
module instr_ram_loader_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    instr_ram_loader u_instr_ram_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    // vector: {read, select, data or expected byte, requirement number}
    localparam int NV = 43;
    localparam logic [14:0] VECS [NV] = '{
        {1'b0, 2'd0, 8'h01, 4'd2},  // R2 load on
        {1'b0, 2'd2, 8'h00, 4'd2},
        {1'b0, 2'd3, 8'h00, 4'd2},
        {1'b0, 2'd1, 8'h0A, 4'd2},  // word 0 = 0D0C0B0A
        {1'b0, 2'd1, 8'h0B, 4'd2},
        {1'b0, 2'd1, 8'h0C, 4'd2},
        {1'b0, 2'd1, 8'h0D, 4'd2},
        {1'b0, 2'd2, 8'h10, 4'd2},
        {1'b0, 2'd1, 8'h11, 4'd2},  // word 0x10 = 44332211
        {1'b0, 2'd1, 8'h22, 4'd2},
        {1'b0, 2'd1, 8'h33, 4'd2},
        {1'b0, 2'd1, 8'h44, 4'd2},
        {1'b1, 2'd2, 8'h11, 4'd3},  // R3 address stepped
        {1'b0, 2'd2, 8'h10, 4'd7},  // R7
        {1'b1, 2'd1, 8'h11, 4'd2},  // R2 byte order
        {1'b1, 2'd1, 8'h22, 4'd2},
        {1'b1, 2'd1, 8'h33, 4'd2},
        {1'b1, 2'd1, 8'h44, 4'd2},
        {1'b1, 2'd2, 8'h11, 4'd8},  // R8 read steps address
        {1'b0, 2'd3, 8'hFF, 4'd4},  // R4
        {1'b1, 2'd3, 8'h01, 4'd4},
        {1'b1, 2'd2, 8'h11, 4'd4},
        {1'b0, 2'd2, 8'hFF, 4'd3},  // address 511
        {1'b0, 2'd1, 8'hA1, 4'd3},
        {1'b0, 2'd1, 8'hB2, 4'd3},
        {1'b0, 2'd1, 8'hC3, 4'd3},
        {1'b0, 2'd1, 8'hD4, 4'd3},
        {1'b1, 2'd2, 8'h00, 4'd3},  // R3 wrap
        {1'b1, 2'd3, 8'h00, 4'd3},
        {1'b0, 2'd3, 8'h01, 4'd8},
        {1'b0, 2'd2, 8'hFF, 4'd8},
        {1'b1, 2'd1, 8'hA1, 4'd8},
        {1'b1, 2'd1, 8'hB2, 4'd8},
        {1'b1, 2'd1, 8'hC3, 4'd8},
        {1'b1, 2'd1, 8'hD4, 4'd8},
        {1'b1, 2'd2, 8'h00, 4'd8},  // R8 read wrap
        {1'b1, 2'd3, 8'h00, 4'd8},
        {1'b1, 2'd1, 8'h0A, 4'd8},
        {1'b0, 2'd3, 8'h00, 4'd7},  // R7 high write clears position
        {1'b1, 2'd1, 8'h0A, 4'd7},
        {1'b0, 2'd2, 8'h10, 4'd7},
        {1'b1, 2'd1, 8'h11, 4'd7},
        {1'b1, 2'd1, 8'h22, 4'd7}
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] sel, input logic [7:0] dat);
        @(negedge clk);
        host_sel = sel; host_wdata = dat; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] sel, input logic [7:0] exp, input int req);
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        #1;
        check(host_rdata, exp, req);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        do_rd(2'd0, 8'h00, 1);
        do_rd(2'd2, 8'h00, 1);
        do_rd(2'd3, 8'h00, 1);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][14]) do_rd(VECS[i][13:12], VECS[i][11:4], int'(VECS[i][3:0]));
            else             do_wr(VECS[i][13:12], VECS[i][11:4]);
        end

        // R5 load clear: data writes ignored
        do_wr(2'd0, 8'h00);
        do_wr(2'd2, 8'h10);
        do_wr(2'd3, 8'h00);
        for (int k = 0; k < 4; k++) do_wr(2'd1, 8'h99);
        do_rd(2'd2, 8'h10, 5);
        do_rd(2'd1, 8'h11, 5);
        do_rd(2'd1, 8'h22, 5);
        do_rd(2'd1, 8'h33, 5);
        do_rd(2'd1, 8'h44, 5);

        // R6 rewind holds address and position, blocks the store
        do_wr(2'd0, 8'h01);
        do_wr(2'd2, 8'h00);
        do_wr(2'd1, 8'h77);
        do_wr(2'd0, 8'h03);
        do_rd(2'd2, 8'h00, 6);
        do_wr(2'd2, 8'h33);
        do_rd(2'd2, 8'h00, 6);
        for (int k = 0; k < 4; k++) do_wr(2'd1, 8'hEE);
        do_rd(2'd0, 8'h03, 9);      // R9
        do_wr(2'd0, 8'h01);
        do_rd(2'd1, 8'h0A, 6);
        do_rd(2'd1, 8'h0B, 6);
        do_rd(2'd1, 8'h0C, 6);
        do_rd(2'd1, 8'h0D, 6);

        // R9 upper control bits not stored
        do_wr(2'd0, 8'hFD);
        do_rd(2'd0, 8'h01, 9);

        // R1 reset mid-run
        do_wr(2'd2, 8'h55);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_rd(2'd0, 8'h00, 1);
        do_rd(2'd2, 8'h00, 1);
        do_rd(2'd3, 8'h00, 1);

        finish_run();
    end

endmodule